// File: doc/BRIEF.md
# Clock-Sweep Not-Recently-Used Frame Victim Selector

This block chooses which physical page frame to give up when a new page must be brought in. It keeps one reference flag and one dirty flag per frame, together with a single rotating hand. Other logic marks frames through a touch port: it sets the reference flag when a frame is used and sets the dirty flag when a frame is written. When a replacement is requested, the hand walks the frames one per cycle. It clears each reference flag it finds set, and it stops on a frame whose reference flag is already clear. That frame is reported as the victim, with a one-cycle done pulse.

A mode input asks the sweep to prefer a frame that is both unreferenced and clean, since such a frame costs no write-back. If a full lap finds no such frame, the sweep settles for the first unreferenced frame it meets. The hand keeps its position between requests, so successive victims rotate around the table.

Top module: `nru_clock_victim`

## Requirements
- R1: After reset every reference flag and dirty flag is 0, the hand is at frame 0, and `done` and `busy` are low. A first plain request after reset therefore returns victim 0 after one examined frame.
- R2: When `touch_en` is high with `touch_idx` below the frame count, a clock edge sets that frame's reference flag if `touch_ref` is 1 and sets its dirty flag if `touch_dirty` is 1. Flags of other frames do not change.
- R3: During a sweep, each examined frame whose reference flag is 1 has that flag cleared. The hand then moves to the next frame, and the frame after the last one is frame 0.
- R4: With `prefer_clean` at 0 when the request is taken, the victim is the first frame from the hand position onward whose reference flag is 0 when the hand reaches it.
- R5: After a victim is chosen, the hand rests one frame past the victim, wrapping from the last frame to frame 0. The next sweep starts from there.
- R6: With `prefer_clean` at 1 when the request is taken, the first lap accepts only a frame whose reference flag and dirty flag are both 0. An unreferenced dirty frame is passed over, and its flags are left unchanged.
- R7: In the clean-preferring mode, if a full lap of the table yields no clean unreferenced frame, the sweep then accepts the first frame whose reference flag is 0, dirty or not.
- R8: A sweep takes one cycle for each examined frame. `done` goes high for exactly one cycle, in the cycle after the accepting frame is examined, with `victim_idx` valid and `busy` low. When no touches set reference flags during the sweep, it examines at most two laps' worth of frames.
- R9: If a touch sets the reference flag of the frame under the hand in the same cycle that the sweep would clear it, the flag stays 1.
- R10: `sweep_req` is ignored while `busy` is high. A request held through a sweep does not change that sweep's victim or length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sweep_req | input | 1 | Start a victim search; taken only when idle |
| prefer_clean | input | 1 | Sampled with the request: 1 prefers clean unreferenced frames |
| touch_en | input | 1 | Touch port strobe |
| touch_idx | input | IDX_W | Frame addressed by the touch |
| touch_ref | input | 1 | Set the addressed frame's reference flag |
| touch_dirty | input | 1 | Set the addressed frame's dirty flag |
| busy | output | 1 | High while a sweep is examining frames |
| done | output | 1 | One-cycle pulse marking a valid victim |
| victim_idx | output | IDX_W | Index of the chosen frame, valid with done |

## Verification
The bench builds the block with five frames. Five is not a power of two, so this size exercises the compare-based wrap variant of the hand. It is also small enough that, from reset, every one of the 1024 combinations of reference and dirty flags can be loaded and swept in both modes. This covers first-hit, full-lap clearing and the clean-preference fallback exhaustively. A long chained run without resets then checks hand persistence across sweeps. Two directed cases, each with a known victim and length, cover a touch colliding with the hand and a request held high during a sweep.

// File: rtl/nru_clock_pkg.sv
package nru_clock_pkg;

   typedef enum logic {
      SW_IDLE = 1'b0,
      SW_SCAN = 1'b1
   } sweep_state_e;

endpackage

// File: rtl/nru_hand_step.sv
module nru_hand_step #(
   parameter int N_FRAMES = 8,
   parameter int IDX_W    = $clog2(N_FRAMES)
) (
   input  logic [IDX_W-1:0] cur,
   output logic [IDX_W-1:0] nxt
);

   localparam bit              IS_POW2 = (N_FRAMES & (N_FRAMES - 1)) == 0;
   localparam logic [IDX_W-1:0] LAST   = IDX_W'(N_FRAMES - 1);

   generate
      if (IS_POW2) begin : g_wrap_natural
         // table size fills the index width: the increment wraps by itself
         assign nxt = cur + 1'b1;
      end else begin : g_wrap_compare
         assign nxt = (cur == LAST) ? '0 : cur + 1'b1;
      end
   endgenerate

endmodule

// File: rtl/nru_frame_flags.sv
module nru_frame_flags #(
   parameter int N_FRAMES = 8,
   parameter int IDX_W    = $clog2(N_FRAMES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                touch_en,
   input  logic [IDX_W-1:0]    touch_idx,
   input  logic                touch_ref,
   input  logic                touch_dirty,
   input  logic                clr_en,
   input  logic [IDX_W-1:0]    clr_idx,
   output logic [N_FRAMES-1:0] ref_q,
   output logic [N_FRAMES-1:0] dirty_q
);

   generate
      for (genvar f = 0; f < N_FRAMES; f++) begin : g_frame
         logic sel_touch;
         logic sel_clr;
         logic r_q;
         logic d_q;

         assign sel_touch = touch_en && (touch_idx == IDX_W'(f));
         assign sel_clr   = clr_en && (clr_idx == IDX_W'(f));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r_q <= 1'b0;
               d_q <= 1'b0;
            end else begin
               // a fresh reference outranks the sweep's clear
               if (sel_touch && touch_ref) begin
                  r_q <= 1'b1;
               end else if (sel_clr) begin
                  r_q <= 1'b0;
               end
               if (sel_touch && touch_dirty) begin
                  d_q <= 1'b1;
               end
            end
         end

         assign ref_q[f]   = r_q;
         assign dirty_q[f] = d_q;
      end
   endgenerate

endmodule

// File: rtl/nru_sweep_ctrl.sv
module nru_sweep_ctrl
   import nru_clock_pkg::*;
#(
   parameter int N_FRAMES = 8,
   parameter int IDX_W    = $clog2(N_FRAMES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sweep_req,
   input  logic                prefer_clean,
   input  logic [N_FRAMES-1:0] ref_q,
   input  logic [N_FRAMES-1:0] dirty_q,
   output logic                clr_en,
   output logic [IDX_W-1:0]    hand_q,
   output logic                busy,
   output logic                done,
   output logic [IDX_W-1:0]    victim_idx
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(N_FRAMES - 1);

   sweep_state_e     state_q;
   logic [IDX_W-1:0] lap_pos_q;
   logic             fallback_q;
   logic             mode_q;
   logic             done_q;
   logic [IDX_W-1:0] victim_q;
   logic [IDX_W-1:0] hand_nxt;
   logic             cur_ref;
   logic             cur_dirty;
   logic             strict;
   logic             accept;

   nru_hand_step #(
      .N_FRAMES (N_FRAMES),
      .IDX_W    (IDX_W)
   ) u_step (
      .cur (hand_q),
      .nxt (hand_nxt)
   );

   always_comb begin
      cur_ref   = ref_q[hand_q];
      cur_dirty = dirty_q[hand_q];
      strict    = mode_q && !fallback_q;
      accept    = (state_q == SW_SCAN) && !cur_ref && !(strict && cur_dirty);
      clr_en    = (state_q == SW_SCAN) && cur_ref;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SW_IDLE;
         hand_q     <= '0;
         lap_pos_q  <= '0;
         fallback_q <= 1'b0;
         mode_q     <= 1'b0;
         done_q     <= 1'b0;
         victim_q   <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            SW_IDLE: begin
               if (sweep_req) begin
                  state_q    <= SW_SCAN;
                  lap_pos_q  <= '0;
                  fallback_q <= 1'b0;
                  mode_q     <= prefer_clean;
               end
            end
            SW_SCAN: begin
               hand_q <= hand_nxt;
               if (accept) begin
                  done_q   <= 1'b1;
                  victim_q <= hand_q;
                  state_q  <= SW_IDLE;
               end else if (lap_pos_q == LAST) begin
                  lap_pos_q  <= '0;
                  fallback_q <= 1'b1;
               end else begin
                  lap_pos_q <= lap_pos_q + 1'b1;
               end
            end
            default: state_q <= SW_IDLE;
         endcase
      end
   end

   assign busy       = (state_q == SW_SCAN);
   assign done       = done_q;
   assign victim_idx = victim_q;

endmodule

// File: rtl/nru_clock_victim.sv
module nru_clock_victim #(
   parameter int N_FRAMES = 8,
   parameter int IDX_W    = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sweep_req,
   input  logic             prefer_clean,
   input  logic             touch_en,
   input  logic [IDX_W-1:0] touch_idx,
   input  logic             touch_ref,
   input  logic             touch_dirty,
   output logic             busy,
   output logic             done,
   output logic [IDX_W-1:0] victim_idx
);

   generate
      if (N_FRAMES < 2) begin : g_bad_frames
         $error("nru_clock_victim: N_FRAMES must be at least 2");
      end
      if (IDX_W != $clog2(N_FRAMES)) begin : g_bad_width
         $error("nru_clock_victim: IDX_W must equal clog2(N_FRAMES)");
      end
   endgenerate

   logic [N_FRAMES-1:0] ref_q;
   logic [N_FRAMES-1:0] dirty_q;
   logic [IDX_W-1:0]    hand_q;
   logic                clr_en;

   nru_frame_flags #(
      .N_FRAMES (N_FRAMES),
      .IDX_W    (IDX_W)
   ) u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .touch_en    (touch_en),
      .touch_idx   (touch_idx),
      .touch_ref   (touch_ref),
      .touch_dirty (touch_dirty),
      .clr_en      (clr_en),
      .clr_idx     (hand_q),
      .ref_q       (ref_q),
      .dirty_q     (dirty_q)
   );

   nru_sweep_ctrl #(
      .N_FRAMES (N_FRAMES),
      .IDX_W    (IDX_W)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .sweep_req    (sweep_req),
      .prefer_clean (prefer_clean),
      .ref_q        (ref_q),
      .dirty_q      (dirty_q),
      .clr_en       (clr_en),
      .hand_q       (hand_q),
      .busy         (busy),
      .done         (done),
      .victim_idx   (victim_idx)
   );

endmodule

// File: rtl/nru_clock_victim_chk.sv
module nru_clock_victim_chk #(
   parameter int N_FRAMES = 8,
   parameter int IDX_W    = $clog2(N_FRAMES)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                touch_en,
   input logic [IDX_W-1:0]    touch_idx,
   input logic                touch_ref,
   input logic                busy,
   input logic                done,
   input logic [IDX_W-1:0]    victim_idx,
   input logic [N_FRAMES-1:0] ref_q,
   input logic [IDX_W-1:0]    hand_q
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(N_FRAMES - 1);

   logic [N_FRAMES-1:0] ref_prev;
   logic [IDX_W-1:0]    hand_prev;
   logic [IDX_W-1:0]    tidx_prev;
   logic [31:0]         scan_cnt;
   logic                saw_set;
   logic                set_here;
   logic                touch_ok;

   assign touch_ok = touch_en && touch_ref && (32'(touch_idx) < N_FRAMES);
   assign set_here = touch_ok && (touch_idx == hand_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_prev  <= '0;
         hand_prev <= '0;
         tidx_prev <= '0;
         scan_cnt  <= '0;
         saw_set   <= 1'b0;
      end else begin
         ref_prev  <= ref_q;
         hand_prev <= hand_q;
         tidx_prev <= touch_idx;
         if (busy) begin
            scan_cnt <= scan_cnt + 1;
            saw_set  <= saw_set || touch_ok;
         end else begin
            scan_cnt <= '0;
            saw_set  <= 1'b0;
         end
      end
   end

   AST_SWEEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      busy && ref_q[hand_q] && !set_here |=> !ref_q[hand_prev]); // R3

   AST_TOUCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      touch_ok |=> ref_q[tidx_prev]); // R9

   AST_VICTIM_UNREF: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !ref_prev[victim_idx]); // R4

   AST_HAND_PAST_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> hand_q == ((victim_idx == LAST) ? '0 : victim_idx + 1'b1)); // R5

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R8

   AST_SWEEP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !saw_set |-> scan_cnt < 32'(2 * N_FRAMES)); // R8

endmodule

bind nru_clock_victim nru_clock_victim_chk #(
   .N_FRAMES (N_FRAMES),
   .IDX_W    (IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .touch_en   (touch_en),
   .touch_idx  (touch_idx),
   .touch_ref  (touch_ref),
   .busy       (busy),
   .done       (done),
   .victim_idx (victim_idx),
   .ref_q      (ref_q),
   .hand_q     (hand_q)
);

// File: tb/test_nru_clock_victim.sv
module test_nru_clock_victim;

   localparam int N  = 5;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          sweep_req;
   logic          prefer_clean;
   logic          touch_en;
   logic [IW-1:0] touch_idx;
   logic          touch_ref;
   logic          touch_dirty;
   logic          busy;
   logic          done;
   logic [IW-1:0] victim_idx;

   always #5 clk = ~clk;

   nru_clock_victim #(.N_FRAMES(N), .IDX_W(IW)) i_nru_clock_victim (
      .clk          (clk),
      .rst_n        (rst_n),
      .sweep_req    (sweep_req),
      .prefer_clean (prefer_clean),
      .touch_en     (touch_en),
      .touch_idx    (touch_idx),
      .touch_ref    (touch_ref),
      .touch_dirty  (touch_dirty),
      .busy         (busy),
      .done         (done),
      .victim_idx   (victim_idx)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit m_ref   [N];
   bit m_dirty [N];
   int m_hand;
   logic [15:0] lfsr = 16'hACE1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int f = 0; f < N; f++) begin
         m_ref[f]   = 1'b0;
         m_dirty[f] = 1'b0;
      end
      m_hand = 0;
   endtask

   task automatic touch(input int idx, input bit r, input bit d);
      touch_en    = 1'b1;
      touch_idx   = IW'(idx);
      touch_ref   = r;
      touch_dirty = d;
      @(negedge clk);
      touch_en = 1'b0;
      if (r) m_ref[idx] = 1'b1;
      if (d) m_dirty[idx] = 1'b1;
   endtask

   // expected result computed from the requirement text
   task automatic predict(input bit mode, output int vic, output int steps);
      int  pos = 0;
      bit  fb  = 1'b0;
      steps = 0;
      vic   = -1;
      while (vic < 0) begin
         steps++;
         if (!m_ref[m_hand] && !(mode && !fb && m_dirty[m_hand])) begin
            vic = m_hand;
         end else begin
            if (m_ref[m_hand]) m_ref[m_hand] = 1'b0;
            pos++;
            if (pos == N) begin
               pos = 0;
               fb  = 1'b1;
            end
         end
         m_hand = (m_hand + 1) % N;
      end
   endtask

   task automatic run_sweep(input bit mode, input string vtag);
      int exp_v;
      int exp_s;
      int cnt = 0;
      predict(mode, exp_v, exp_s);
      sweep_req    = 1'b1;
      prefer_clean = mode;
      @(negedge clk);
      sweep_req = 1'b0;
      do begin
         @(negedge clk);
         cnt++;
      end while (!done && cnt < 4 * N);
      check(done == 1'b1, "R8 done", int'(done), 1);
      check(int'(victim_idx) == exp_v, vtag, int'(victim_idx), exp_v);
      check(cnt == exp_s, "R8 length", cnt, exp_s);
      check(busy == 1'b0, "R8 busy", int'(busy), 0);
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      sweep_req    = 1'b0;
      prefer_clean = 1'b0;
      touch_en     = 1'b0;
      touch_idx    = '0;
      touch_ref    = 1'b0;
      touch_dirty  = 1'b0;

      // R1: reset state and first sweep
      do_reset();
      check(done == 1'b0, "R1 done", int'(done), 0);
      check(busy == 1'b0, "R1 busy", int'(busy), 0);
      run_sweep(1'b0, "R1 victim");

      // exhaustive flag patterns, both modes (R2 R4 R6 R7)
      for (int mode = 0; mode < 2; mode++) begin
         for (int pat = 0; pat < 1024; pat++) begin
            int ev;
            int es;
            string tag;
            do_reset();
            for (int f = 0; f < N; f++) begin
               if (pat[f] || pat[f+N]) touch(f, pat[f], pat[f+N]);
            end
            for (int f = 0; f < N; f++) begin
               m_ref[f] = pat[f];
               m_dirty[f] = pat[f+N];
            end
            begin
               bit sr[N];
               int sh;
               sr = m_ref;
               sh = m_hand;
               predict(mode[0], ev, es);
               m_ref  = sr;
               m_hand = sh;
            end
            if (mode == 0) tag = "R2 R4 victim";
            else if (es <= N) tag = "R6 victim";
            else tag = "R7 victim";
            run_sweep(mode[0], tag);
         end
      end

      // chained sweeps without reset: hand persistence and clearing (R3 R5)
      do_reset();
      for (int k = 0; k < 400; k++) begin
         int nt;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         nt = int'(lfsr[1:0]);
         for (int t = 0; t < nt; t++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            touch(int'(lfsr[7:0]) % N, lfsr[8], lfsr[9] & lfsr[10]);
         end
         run_sweep(lfsr[11], "R3 R5 victim");
      end

      // R9: touch on the frame under the hand in its first examined cycle
      do_reset();
      for (int f = 0; f < N; f++) touch(f, 1'b1, 1'b0);
      begin
         int cnt = 0;
         sweep_req    = 1'b1;
         prefer_clean = 1'b0;
         @(negedge clk);
         sweep_req = 1'b0;
         touch_en  = 1'b1;
         touch_idx = '0;
         touch_ref = 1'b1;
         touch_dirty = 1'b0;
         do begin
            @(negedge clk);
            touch_en = 1'b0;
            cnt++;
         end while (!done && cnt < 4 * N);
         check(int'(victim_idx) == 1, "R9 victim", int'(victim_idx), 1);
         check(cnt == 7, "R9 length", cnt, 7);
         for (int f = 0; f < N; f++) m_ref[f] = 1'b0;
         m_hand = 2;
      end
      run_sweep(1'b0, "R9 follow-up");

      // R10: request held high through a sweep
      do_reset();
      for (int f = 0; f < 4; f++) touch(f, 1'b1, 1'b0);
      begin
         int cnt = 0;
         sweep_req    = 1'b1;
         prefer_clean = 1'b0;
         @(negedge clk);
         do begin
            @(negedge clk);
            cnt++;
            if (cnt == 3) sweep_req = 1'b0;
         end while (!done && cnt < 4 * N);
         check(int'(victim_idx) == 4, "R10 victim", int'(victim_idx), 4);
         check(cnt == 5, "R10 length", cnt, 5);
         @(negedge clk);
         check(busy == 1'b0, "R10 idle after", int'(busy), 0);
         check(done == 1'b0, "R8 single pulse", int'(done), 0);
         for (int f = 0; f < N; f++) m_ref[f] = 1'b0;
         m_hand = 0;
      end
      run_sweep(1'b0, "R10 follow-up");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule